// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single bytes to and from a smart card over one shared, bidirectional data line. It operates half duplex: the transmitter pulls the line low for zero bits and releases it for one bits, so the line behaves like an open-drain wire with an external pull-up. While the transmitter is disabled, the same line feeds the receiver. Either the T=0 or the T=1 protocol may be selected. Both use a fixed character of one start bit, eight data bits sent least significant bit first, and a parity bit, followed by one or two stop bits. No other character-length setting exists.

The bit period is one elementary time unit. It lasts floor(Fi/Di) card clock cycles and is counted on a card clock strobe. A small sequential divider recomputes this period whenever Fi or Di changes. Parity is even unless odd parity is selected. Software uses odd parity, together with a bytewise inversion of the data, for the inverse convention. If the transmitter and the receiver are enabled at the same time, the block refuses both and raises a conflict flag.

Top module: `sc_xcvr`

## Requirements
- R1: Only mode value 3'b100 (T=0) or 3'b110 (T=1) activates the block. With any other mode value, io_oe stays low, tx_ready stays low and the receiver ignores the line.
- R2: A transmitted character is a start bit of 0, then data bits 0 to 7, then the parity bit, then the stop bit(s) of 1. Each bit lasts exactly floor(fi/di) strobed card clock cycles, with a minimum of 2.
- R3: The parity bit is the XOR of the eight data bits when odd_par is 0, which gives even parity. It is the inverse of that XOR when odd_par is 1. The receiver checks against the same rule.
- R4: After a byte is accepted, tx_ready stays low for 11 bit periods when two_stop is 0, and for 12 bit periods when two_stop is 1.
- R5: The line is only ever pulled low. io_oe is 1 exactly while a 0 bit is being sent, and is 0 when the line is idle.
- R6: A valid frame on io_in yields one single-cycle rx_valid pulse, with rx_data holding the eight data bits.
- R7: A low pulse on the idle line that has ended before half a bit period is rejected as a start bit and produces no rx_valid.
- R8: A received parity mismatch sets par_err. par_err stays set through later characters until rx_en is low, and it clears while rx_en is low.
- R9: With tx_en and rx_en both high, cfg_err is 1 and tx_ready is 0. io_oe stays low even if tx_valid is high, and no character is received.
- R10: While tx_en is high, incoming frames on io_in produce no rx_valid.
- R11: During and right after reset, io_oe, rx_valid and par_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_tick | input | 1 | One-cycle strobe per card clock period |
| mode | input | 3 | Protocol select: 3'b100 for T=0, 3'b110 for T=1 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low also clears par_err |
| two_stop | input | 1 | 1 selects two stop bits |
| odd_par | input | 1 | 1 selects odd parity |
| fi | input | FI_W | Clock rate conversion factor |
| di | input | DI_W | Bit rate adjustment factor (0 treated as 1) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Single-cycle pulse when rx_data is updated |
| par_err | output | 1 | Sticky received parity error |
| cfg_err | output | 1 | Transmitter and receiver both enabled |
| io_in | input | 1 | Sensed level of the shared data line |
| io_oe | output | 1 | 1 pulls the shared line low |

## Verification
The bench targets off-by-one errors in bit timing. It times every bit of sent frames at mid-bit for two Fi/Di ratios, one of which does not divide evenly. It also measures how long tx_ready stays low for one and for two stop bits. A design with a wrong reload value or a wrong count of stop bits would shift the sampled bits or give the wrong busy length. Both parity senses are checked in both directions, and the bench confirms that a parity error survives a following good byte, because a design that cleared the flag on each character would lose it. Start-bit glitches, simultaneous enables, transmit-side blocking of the receiver and an unsupported mode value each probe a gate: a design without that gate would drive the line or emit a phantom byte.

// File: rtl/sc_pkg.sv
// Shared constants, state types and helpers for the smart card transceiver.
// Assumes a single clock domain; the card clock arrives as an enable strobe.
package sc_pkg;

    localparam logic [2:0] MODE_T0 = 3'b100;
    localparam logic [2:0] MODE_T1 = 3'b110;

    localparam int DATA_BITS = 8;
    // start + data + parity + one stop
    localparam int FRAME_MIN = DATA_BITS + 3;

    typedef enum logic [0:0] {TX_IDLE, TX_SEND} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    // Parity bit for a byte under the selected sense
    function automatic logic par_bit(input logic [DATA_BITS-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sc_etu_div.sv
// Sequential restoring divider producing the bit period floor(fi/di).
// Restarts whenever fi or di changes; etu_ok is low while computing.
// Assumes FI_W >= DI_W and FI_W >= 2; di of zero is treated as one.
module sc_etu_div #(
    parameter int FI_W = 12,
    parameter int DI_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FI_W-1:0] fi,
    input  logic [DI_W-1:0] di,
    output logic [FI_W-1:0] etu,
    output logic            etu_ok
);
    localparam int CNT_W = $clog2(FI_W + 1);

    logic [FI_W-1:0]  fi_q;
    logic [DI_W-1:0]  di_q;
    logic [FI_W-1:0]  dvd;
    logic [FI_W-1:0]  quo;
    logic [FI_W:0]    rem;
    logic [CNT_W-1:0] cnt;
    logic             busy;

    logic             changed;
    logic [FI_W:0]    rem_sh;
    logic [FI_W:0]    dvs;
    logic             ge;
    logic [FI_W-1:0]  quo_n;

    // Next-step arithmetic of one restoring division stage
    always_comb begin
        changed = (fi != fi_q) || (di != di_q);
        rem_sh  = {rem[FI_W-1:0], dvd[FI_W-1]};
        dvs     = (di_q == '0) ? {{FI_W{1'b0}}, 1'b1}
                               : {{(FI_W+1-DI_W){1'b0}}, di_q};
        ge      = (rem_sh >= dvs);
        quo_n   = {quo[FI_W-2:0], ge};
    end

    // Divider sequencing: restart on change, one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi_q   <= '0;
            di_q   <= '0;
            dvd    <= '0;
            quo    <= '0;
            rem    <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            etu    <= FI_W'(2);
            etu_ok <= 1'b0;
        end else if (changed) begin
            fi_q   <= fi;
            di_q   <= di;
            dvd    <= fi;
            quo    <= '0;
            rem    <= '0;
            cnt    <= CNT_W'(FI_W);
            busy   <= 1'b1;
            etu_ok <= 1'b0;
        end else if (busy) begin
            dvd <= dvd << 1;
            rem <= ge ? (rem_sh - dvs) : rem_sh;
            quo <= quo_n;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                busy   <= 1'b0;
                etu_ok <= 1'b1;
                etu    <= (quo_n < FI_W'(2)) ? FI_W'(2) : quo_n;
            end
        end
    end

endmodule

// File: rtl/sc_tx.sv
// Character transmitter: shifts start, eight data bits LSB first, parity
// and one or two stop bits onto an open-drain line, one bit per etu.
// Assumes etu >= 2; dropping act aborts the frame and releases the line.
module sc_tx
    import sc_pkg::*;
#(
    parameter int ETU_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act,
    input  logic                 tick,
    input  logic [ETU_W-1:0]     etu,
    input  logic                 etu_ok,
    input  logic                 two_stop,
    input  logic                 odd_par,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 valid,
    output logic                 ready,
    output logic                 drive_low
);
    localparam int SR_W  = FRAME_MIN + 1;
    localparam int BIT_W = $clog2(SR_W + 1);

    tx_state_t        st;
    logic [SR_W-1:0]  sr;
    logic [BIT_W-1:0] left;
    logic [ETU_W-1:0] tmr;

    // Handshake and line drive derived from state
    always_comb begin
        ready     = act && etu_ok && (st == TX_IDLE);
        drive_low = (st == TX_SEND) && !sr[0];
    end

    // Frame load, bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            sr   <= '1;
            left <= '0;
            tmr  <= '0;
        end else if (!act) begin
            st <= TX_IDLE;
            sr <= '1;
        end else if (st == TX_IDLE) begin
            if (valid && ready) begin
                sr   <= {2'b11, par_bit(data, odd_par), data, 1'b0};
                left <= two_stop ? BIT_W'(SR_W) : BIT_W'(FRAME_MIN);
                tmr  <= etu;
                st   <= TX_SEND;
            end
        end else if (tick) begin
            if (tmr == ETU_W'(1)) begin
                sr   <= {1'b1, sr[SR_W-1:1]};
                left <= left - 1'b1;
                tmr  <= etu;
                if (left == BIT_W'(1)) begin
                    st <= TX_IDLE;
                end
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sc_rx.sv
// Character receiver: synchronizes the line, detects a falling edge,
// confirms the start bit at mid-bit, then samples eight data bits and
// parity at mid-bit and reports the byte at the middle of the stop bit.
// Assumes etu >= 2; dropping act returns to idle.
module sc_rx
    import sc_pkg::*;
#(
    parameter int ETU_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act,
    input  logic                 tick,
    input  logic [ETU_W-1:0]     etu,
    input  logic                 etu_ok,
    input  logic                 odd_par,
    input  logic                 line,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 perr
);
    localparam int SH_W  = DATA_BITS + 1;
    localparam int IDX_W = $clog2(SH_W + 1);

    rx_state_t        st;
    logic [2:0]       sync;
    logic [SH_W-1:0]  sh;
    logic [IDX_W-1:0] idx;
    logic [ETU_W-1:0] tmr;
    logic             mid;

    // Mid-bit sample point reached on this strobe
    always_comb mid = tick && (tmr == ETU_W'(1));

    // Two-stage synchronizer plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 3'b111;
        else        sync <= {sync[1:0], line};
    end

    // Receive sequencing and byte delivery
    always_ff @(posedge clk) begin
        valid <= 1'b0;
        perr  <= 1'b0;
        if (!rst_n) begin
            st   <= RX_IDLE;
            sh   <= '0;
            idx  <= '0;
            tmr  <= '0;
            data <= '0;
        end else if (!act || !etu_ok) begin
            st <= RX_IDLE;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (sync[2] && !sync[1]) begin
                        tmr <= etu >> 1;
                        st  <= RX_START;
                    end
                end
                RX_START: begin
                    if (mid) begin
                        tmr <= etu;
                        idx <= '0;
                        st  <= sync[1] ? RX_IDLE : RX_DATA;
                    end else if (tick) begin
                        tmr <= tmr - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (mid) begin
                        sh  <= {sync[1], sh[SH_W-1:1]};
                        idx <= idx + 1'b1;
                        tmr <= etu;
                        if (idx == IDX_W'(SH_W - 1)) st <= RX_STOP;
                    end else if (tick) begin
                        tmr <= tmr - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (mid) begin
                        data  <= sh[DATA_BITS-1:0];
                        valid <= 1'b1;
                        perr  <= (par_bit(sh[DATA_BITS-1:0], odd_par) != sh[SH_W-1]);
                        st    <= RX_IDLE;
                    end else if (tick) begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sc_xcvr.sv
// Top of the half-duplex smart card character transceiver. Gates the
// transmitter and receiver by mode and enables, refuses simultaneous
// enables, shares one bit-period divider, and keeps the sticky parity flag.
// Assumes io_in is the wired-AND of the card and this block's pull-down.
module sc_xcvr
    import sc_pkg::*;
#(
    parameter int FI_W = 12,
    parameter int DI_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            card_tick,
    input  logic [2:0]      mode,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic            two_stop,
    input  logic            odd_par,
    input  logic [FI_W-1:0] fi,
    input  logic [DI_W-1:0] di,
    input  logic [7:0]      tx_data,
    input  logic            tx_valid,
    output logic            tx_ready,
    output logic [7:0]      rx_data,
    output logic            rx_valid,
    output logic            par_err,
    output logic            cfg_err,
    input  logic            io_in,
    output logic            io_oe
);
    logic [FI_W-1:0] etu;
    logic            etu_ok;
    logic            mode_ok;
    logic            tx_act;
    logic            rx_act;
    logic            perr_hit;

    // Direction arbitration: one side at a time, neither on conflict
    always_comb begin
        mode_ok = (mode == MODE_T0) || (mode == MODE_T1);
        cfg_err = tx_en && rx_en;
        tx_act  = mode_ok && tx_en && !rx_en;
        rx_act  = mode_ok && rx_en && !tx_en;
    end

    sc_etu_div #(.FI_W(FI_W), .DI_W(DI_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .fi     (fi),
        .di     (di),
        .etu    (etu),
        .etu_ok (etu_ok)
    );

    sc_tx #(.ETU_W(FI_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (tx_act),
        .tick      (card_tick),
        .etu       (etu),
        .etu_ok    (etu_ok),
        .two_stop  (two_stop),
        .odd_par   (odd_par),
        .data      (tx_data),
        .valid     (tx_valid),
        .ready     (tx_ready),
        .drive_low (io_oe)
    );

    sc_rx #(.ETU_W(FI_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (rx_act),
        .tick    (card_tick),
        .etu     (etu),
        .etu_ok  (etu_ok),
        .odd_par (odd_par),
        .line    (io_in),
        .data    (rx_data),
        .valid   (rx_valid),
        .perr    (perr_hit)
    );

    // Sticky parity error, cleared while the receiver is disabled
    always_ff @(posedge clk) begin
        if (!rst_n)        par_err <= 1'b0;
        else if (!rx_en)   par_err <= 1'b0;
        else if (perr_hit) par_err <= 1'b1;
    end

endmodule

// File: rtl/sc_xcvr_chk.sv
// Property checker for sc_xcvr, attached through bind below.
module sc_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       tx_en,
    input logic       rx_en,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       par_err,
    input logic       cfg_err,
    input logic       io_oe
);
    // R5
    drive_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (tx_en && !rx_en));

    // R1
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'b100 && mode != 3'b110) |-> (!io_oe && !tx_ready));

    // R9
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!tx_ready && !io_oe));

    // R10
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> !rx_valid);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && rx_en) |=> par_err);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !par_err);

endmodule

bind sc_xcvr sc_xcvr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .par_err  (par_err),
    .cfg_err  (cfg_err),
    .io_oe    (io_oe)
);

// File: tb/tb_sc_xcvr.sv
// Directed bench for sc_xcvr; one task per scenario.
module tb_sc_xcvr;
    localparam int FI_W = 12;
    localparam int DI_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            card_tick = 1'b1;
    logic [2:0]      mode = 3'b100;
    logic            tx_en = 1'b0;
    logic            rx_en = 1'b0;
    logic            two_stop = 1'b0;
    logic            odd_par = 1'b0;
    logic [FI_W-1:0] fi = 12'd40;
    logic [DI_W-1:0] di = 6'd2;
    logic [7:0]      tx_data = 8'h00;
    logic            tx_valid = 1'b0;
    logic            tx_ready;
    logic [7:0]      rx_data;
    logic            rx_valid;
    logic            par_err;
    logic            cfg_err;
    logic            io_in;
    logic            io_oe;
    logic            card_hi = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    int got_cnt = 0;
    logic [7:0] got_data = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign io_in = card_hi & ~io_oe;

    sc_xcvr #(.FI_W(FI_W), .DI_W(DI_W)) dut (
        .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .mode(mode),
        .tx_en(tx_en), .rx_en(rx_en), .two_stop(two_stop), .odd_par(odd_par),
        .fi(fi), .di(di), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .par_err(par_err), .cfg_err(cfg_err), .io_in(io_in), .io_oe(io_oe)
    );

    // Count received pulses at the ports
    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  <= got_cnt + 1;
            got_data <= rx_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic frame_bit(input logic [7:0] d, input logic odd, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return (^d) ^ odd;
        return 1'b1;
    endfunction

    // Send one byte and check each line bit at mid-bit (R2, R3, R5)
    task automatic tx_frame(input logic [7:0] d, input int etu, input string req);
        int errs = 0;
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_cyc(etu / 2);
        for (int i = 0; i < 11; i++) begin
            if (io_oe !== ~frame_bit(d, odd_par, i)) begin
                errs++;
                chk(1'b0, req, int'(io_oe), int'(~frame_bit(d, odd_par, i)));
            end
            wait_cyc(etu);
        end
        chk(errs == 0, req, errs, 0);
        wait_cyc(2 * etu);
        chk(io_oe == 1'b0, "R5 idle release", int'(io_oe), 0);
    endtask

    // Card drives one frame on the line
    task automatic card_frame(input logic [7:0] d, input bit bad, input int etu);
        for (int i = 0; i < 11; i++) begin
            card_hi = frame_bit(d, odd_par, i) ^ ((i == 9) ? bad : 1'b0);
            wait_cyc(etu);
        end
        card_hi = 1'b1;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(io_oe == 1'b0 && rx_valid == 1'b0 && par_err == 1'b0, "R11 in reset",
            {io_oe, rx_valid, par_err}, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        chk(io_oe == 1'b0 && rx_valid == 1'b0 && par_err == 1'b0, "R11 after reset",
            {io_oe, rx_valid, par_err}, 0);
    endtask

    task automatic t_tx_basic();
        mode = 3'b100; tx_en = 1'b1; odd_par = 1'b0;
        fi = 12'd40; di = 6'd2;
        wait_cyc(20);
        chk(tx_ready == 1'b1, "R2 ready", int'(tx_ready), 1);
        tx_frame(8'hA5, 20, "R2 R3 even T0 A5");
        tx_frame(8'h01, 20, "R2 R3 even T0 01");
    endtask

    task automatic t_tx_t1_odd();
        mode = 3'b110; odd_par = 1'b1;
        fi = 12'd93; di = 6'd4;
        wait_cyc(20);
        tx_frame(8'h3C, 23, "R2 R3 R1 odd T1 floor");
        tx_frame(8'hFF, 23, "R3 odd T1 FF");
        odd_par = 1'b0;
    endtask

    task automatic t_stop_len(input bit two, input int etu);
        int n = 0;
        two_stop = two;
        tx_data  = 8'h5A;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == (two ? 12 : 11) * etu, two ? "R4 two stop" : "R4 one stop",
            n, (two ? 12 : 11) * etu);
        two_stop = 1'b0;
    endtask

    task automatic t_rx();
        int base;
        tx_en = 1'b0; rx_en = 1'b1; mode = 3'b100;
        fi = 12'd40; di = 6'd2;
        wait_cyc(20);
        base = got_cnt;
        card_frame(8'hC3, 1'b0, 20);
        chk(got_cnt == base + 1 && got_data == 8'hC3, "R6 rx C3", int'(got_data), 'hC3);
        chk(par_err == 1'b0, "R8 no err", int'(par_err), 0);
        odd_par = 1'b1;
        card_frame(8'h7E, 1'b0, 20);
        chk(got_cnt == base + 2 && got_data == 8'h7E, "R6 R3 rx odd", int'(got_data), 'h7E);
        chk(par_err == 1'b0, "R3 odd rx ok", int'(par_err), 0);
        card_frame(8'h10, 1'b1, 20);
        chk(par_err == 1'b1, "R8 parity err set", int'(par_err), 1);
        odd_par = 1'b0;
        card_frame(8'h22, 1'b0, 20);
        chk(par_err == 1'b1 && got_data == 8'h22, "R8 sticky", int'(par_err), 1);
        rx_en = 1'b0;
        wait_cyc(3);
        chk(par_err == 1'b0, "R8 cleared", int'(par_err), 0);
        rx_en = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_glitch();
        int base = got_cnt;
        card_hi = 1'b0;
        wait_cyc(3);
        card_hi = 1'b1;
        wait_cyc(3 * 20);
        chk(got_cnt == base, "R7 glitch rejected", got_cnt - base, 0);
        card_frame(8'h96, 1'b0, 20);
        chk(got_cnt == base + 1 && got_data == 8'h96, "R7 recovers", int'(got_data), 'h96);
    endtask

    task automatic t_conflict();
        int base = got_cnt;
        int drv = 0;
        tx_en = 1'b1; rx_en = 1'b1;
        wait_cyc(2);
        chk(cfg_err == 1'b1 && tx_ready == 1'b0, "R9 refuse", {cfg_err, tx_ready}, 2);
        tx_data = 8'h00; tx_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (io_oe) drv++;
        end
        tx_valid = 1'b0;
        chk(drv == 0, "R9 no drive", drv, 0);
        card_frame(8'h44, 1'b0, 20);
        chk(got_cnt == base, "R9 no receive", got_cnt - base, 0);
        rx_en = 1'b0;
        wait_cyc(2);
        chk(cfg_err == 1'b0, "R9 flag drops", int'(cfg_err), 0);
    endtask

    task automatic t_rx_blocked();
        int base = got_cnt;
        tx_en = 1'b1; rx_en = 1'b0;
        card_frame(8'h81, 1'b0, 20);
        chk(got_cnt == base, "R10 rx blocked by tx_en", got_cnt - base, 0);
        tx_en = 1'b0;
    endtask

    task automatic t_bad_mode();
        int base = got_cnt;
        mode = 3'b000; tx_en = 1'b1;
        wait_cyc(2);
        chk(tx_ready == 1'b0, "R1 tx off", int'(tx_ready), 0);
        tx_en = 1'b0; rx_en = 1'b1;
        card_frame(8'h5F, 1'b0, 20);
        chk(got_cnt == base, "R1 rx off", got_cnt - base, 0);
        mode = 3'b110;
        wait_cyc(2);
        card_frame(8'h5F, 1'b0, 20);
        chk(got_cnt == base + 1 && got_data == 8'h5F, "R1 T1 rx", int'(got_data), 'h5F);
        rx_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_tx_basic();
        t_tx_t1_odd();
        fi = 12'd40; di = 6'd2; mode = 3'b100;
        wait_cyc(20);
        t_stop_len(1'b0, 20);
        t_stop_len(1'b1, 20);
        t_rx();
        t_glitch();
        t_conflict();
        t_rx_blocked();
        t_bad_mode();
        done = 1'b1;
        report();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

endmodule